// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog peripheral for a system that must be pulled back into a known state when its software stops servicing it. A 32-bit down-counter runs from a programmed load value. Software keeps the system alive by writing a fixed key word to a restart register, which copies the load value back into the counter. If the counter reaches zero while the watchdog is enabled, a sticky expiry state is raised. That state drives up to three outputs: a system reset request, an interrupt request and a general expiry signal. Each output has its own gate bit in the control register.

All registers sit on the peripheral clock. The counter can tick on every peripheral clock, or once per rising edge of a slower external clock. The external clock is brought into the peripheral domain through a flop synchroniser and an edge detector. The external rate must be well below half the peripheral rate. The timeout is the load value divided by the chosen tick rate.

The intended programming order has four steps. Write the load value. Write the key. Write the control word with the enable bit clear, so that the tick source settles. Then write it again with the enable bit set. Writing zero to the control register stops the watchdog.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control register reads 0, the load register reads 0xFFFFFFFF, the counter reads 0xFFFFFFFF, and all three expiry outputs are low.
- R2: A read returns data on `regRdata` in the same cycle as the address. Offset 0x0 returns the counter. Offset 0x4 returns the load value. Offset 0xC returns the control register in bits [4:0] with zeros above. Offset 0x8 and every unmapped offset read as zero.
- R3: Writing exactly 0x00005AB9 to offset 0x8 copies the load value into the counter and clears the expiry state at the next clock edge. Any other value written there changes nothing.
- R4: While control bit 0 (enable) is set and bit 4 (source) is clear, the counter drops by one on every clock edge.
- R5: While bit 0 and bit 4 are both set, the counter drops by one for each rising edge of `extClk`. The drop happens at the third peripheral clock edge after the rising edge, and without `extClk` edges the counter does not move.
- R6: The counter stops at zero and never wraps.
- R7: One clock after the counter reads zero with enable set, the expiry state is raised. `sysRstReq` follows it when control bit 1 is set, `irqReq` when bit 2 is set, and `expirySignal` when bit 3 is set.
- R8: The expiry outputs stay asserted until a key restart or until enable is cleared. After control is written with zero, all outputs are low from the next cycle.
- R9: While enable is clear the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; all registers and the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| extClk | input | 1 | Slow external tick clock, asynchronous to `clk` |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| sysRstReq | output | 1 | System reset request on expiry |
| irqReq | output | 1 | Interrupt request on expiry |
| expirySignal | output | 1 | General expiry signal |

## Verification
The bench builds the block with its default parameters: a 32-bit counter and data path, a 4-bit offset, the 0x5AB9 key and two synchroniser stages. Expiry is still reached in a few dozen cycles, because small values are written to the load register. This leaves the full-width reset value and the holding at zero both observable, with no reduced-width variant. The external tick is exercised both as a single hand-placed edge, which measures the three-cycle latency, and as a free-running clock at one eighth of the peripheral rate, which checks the one-drop-per-edge rate.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Control register field positions
  localparam int CTRL_W  = 5;
  localparam int BIT_EN  = 0;
  localparam int BIT_RST = 1;
  localparam int BIT_IRQ = 2;
  localparam int BIT_EXT = 3;
  localparam int BIT_SRC = 4;

  // Register offsets
  localparam int OFS_COUNT   = 'h0;
  localparam int OFS_LOAD    = 'h4;
  localparam int OFS_RESTART = 'h8;
  localparam int OFS_CTRL    = 'hC;

  // Strobes and levels handed from control to datapath
  typedef struct packed {
    logic reload;
    logic enable;
    logic tickExt;
    logic rstGate;
    logic irqGate;
    logic extGate;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extClk,
  output logic tickPulse
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  // Stages [0..SYNC_STAGES-1] synchronise; the last holds the previous level
  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[PIPE_W-2:0], extClk};
  end

  assign tickPulse = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

  // R5: one detected edge yields a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> !tickPulse);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 4,
  parameter int          CNT_W   = 32,
  parameter logic [31:0] KEY_VAL = 32'h0000_5AB9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cntVal,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  loadVal,
  output wdtStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_LOAD    = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
  localparam logic [DATA_W-1:0] KEY_WORD  = DATA_W'(KEY_VAL);

  logic [CTRL_W-1:0] ctrlQ;
  logic [CNT_W-1:0]  loadQ;
  logic wrCtrl, wrLoad, keyHit;

  assign wrCtrl = wrEn && (addr == A_CTRL);
  assign wrLoad = wrEn && (addr == A_LOAD);
  assign keyHit = wrEn && (addr == A_RESTART) && (wdata == KEY_WORD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      loadQ <= '1;
    end else begin
      if (wrCtrl) ctrlQ <= wdata[CTRL_W-1:0];
      if (wrLoad) loadQ <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    strb.reload  = keyHit;
    strb.enable  = ctrlQ[BIT_EN];
    strb.tickExt = ctrlQ[BIT_SRC];
    strb.rstGate = ctrlQ[BIT_RST];
    strb.irqGate = ctrlQ[BIT_IRQ];
    strb.extGate = ctrlQ[BIT_EXT];
  end

  assign loadVal = loadQ;

  always_comb begin
    unique case (addr)
      A_COUNT: rdata = DATA_W'(cntVal);
      A_LOAD:  rdata = DATA_W'(loadQ);
      A_CTRL:  rdata = DATA_W'(ctrlQ);
      default: rdata = '0;
    endcase
  end

  // R3: a write to the restart offset with another value leaves the load register alone
  a_r3_restart_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_RESTART) |=> $stable(loadQ));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             extTick,
  output logic [CNT_W-1:0] cntVal,
  output logic             sysRstReq,
  output logic             irqReq,
  output logic             expirySignal
);
  logic [CNT_W-1:0] cntQ;
  logic             expQ;
  logic             stepOk, atZero;

  assign stepOk = strb.tickExt ? extTick : 1'b1;
  assign atZero = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 cntQ <= '1;
    else if (strb.reload)                      cntQ <= loadVal;
    else if (strb.enable && stepOk && !atZero) cntQ <= cntQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            expQ <= 1'b0;
    else if (strb.reload || !strb.enable) expQ <= 1'b0;
    else if (atZero)                      expQ <= 1'b1;
  end

  assign cntVal       = cntQ;
  assign sysRstReq    = expQ & strb.rstGate;
  assign irqReq       = expQ & strb.irqGate;
  assign expirySignal = expQ & strb.extGate;

  // R6: zero is held unless reloaded
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (atZero && !strb.reload) |=> (cntQ == '0));
  // R9: disabled counter is frozen
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.enable && !strb.reload) |=> $stable(cntQ));
  // R3: key restart loads the counter and clears expiry
  a_r3_reload: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (cntQ == $past(loadVal)) && !expQ);
  // R8: clearing enable silences every output next cycle
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enable |=> !(sysRstReq || irqReq || expirySignal));
  // R7: expiry only follows a zero count
  a_r7_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(expQ) |-> ($past(cntQ) == '0));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 4,
  parameter int          CNT_W       = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] KEY_VAL     = 32'h0000_5AB9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClk,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              sysRstReq,
  output logic              irqReq,
  output logic              expirySignal
);
  wdtStrobe_t       strb;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] loadVal;
  logic             extTick;

  wdt_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .KEY_VAL(KEY_VAL)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wdata(regWdata),
    .cntVal(cntVal), .rdata(regRdata), .loadVal(loadVal), .strb(strb)
  );

  wdt_tick #(.SYNC_STAGES(SYNC_STAGES)) i_tick (
    .clk(clk), .rstN(rstN), .extClk(extClk), .tickPulse(extTick)
  );

  wdt_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .extTick(extTick),
    .cntVal(cntVal), .sysRstReq(sysRstReq), .irqReq(irqReq),
    .expirySignal(expirySignal)
  );
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam int          SYNC = 2;
  localparam logic [31:0] KEY  = 32'h0000_5AB9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extClk = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sysRstReq, irqReq, expirySignal;

  int checks = 0;
  int fails  = 0;

  keyed_watchdog #(.SYNC_STAGES(SYNC), .KEY_VAL(KEY)) i_keyed_watchdog (
    .clk(clk), .rstN(rstN), .extClk(extClk), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .sysRstReq(sysRstReq), .irqReq(irqReq), .expirySignal(expirySignal)
  );

  always #4 clk = ~clk;

  // External clock source: free-running or held at a level
  bit extRun = 0;
  bit extLevel = 0;
  int extHalf = 4;
  int extDiv = 0;
  always @(posedge clk) begin
    #1;
    if (extRun) begin
      extDiv++;
      if (extDiv >= extHalf) begin
        extDiv = 0;
        extClk = ~extClk;
      end
    end else begin
      extClk = extLevel;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [4:0]  mCtrl = '0;
  logic [31:0] mLoad = '1;
  logic [31:0] mCnt  = '1;
  bit          mExp  = 0;
  bit          extSeen[$];

  initial for (int i = 0; i <= SYNC; i++) extSeen.push_front(1'b0);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = '0; mLoad = '1; mCnt = '1; mExp = 0;
      extSeen.delete();
      for (int i = 0; i <= SYNC; i++) extSeen.push_front(1'b0);
    end else begin
      bit rise, tick, restart, en;
      logic [31:0] oldCnt;
      rise = extSeen[SYNC-1] && !extSeen[SYNC];
      extSeen.push_front(extClk);
      void'(extSeen.pop_back());
      en = mCtrl[0];
      tick = mCtrl[4] ? rise : 1'b1;
      restart = regWrEn && regAddr == 4'h8 && regWdata == KEY;
      oldCnt = mCnt;
      if (restart) mCnt = mLoad;
      else if (en && tick && mCnt != 0) mCnt = mCnt - 1;
      if (restart || !en) mExp = 0;
      else if (oldCnt == 0) mExp = 1;
      if (regWrEn && regAddr == 4'hC) mCtrl = regWdata[4:0];
      if (regWrEn && regAddr == 4'h4) mLoad = regWdata;
    end
  end

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [31:0] expRd;
      logic [2:0]  expOut, actOut;
      case (regAddr)
        4'h0:    expRd = mCnt;
        4'h4:    expRd = mLoad;
        4'hC:    expRd = {27'd0, mCtrl};
        default: expRd = '0;
      endcase
      expOut = {mExp & mCtrl[3], mExp & mCtrl[2], mExp & mCtrl[1]};
      actOut = {expirySignal, irqReq, sysRstReq};
      check(regRdata === expRd, "R2 per-cycle read", regRdata, expRd);
      check(actOut === expOut, "R7 per-cycle outputs", {29'd0, actOut}, {29'd0, expOut});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    regAddr = a;
    @(negedge clk);
    d = regRdata;
  endtask

  function automatic logic [31:0] outs();
    return {29'd0, expirySignal, irqReq, sysRstReq};
  endfunction

  bit done = 0;
  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    rd(4'h0, a); check(a == 32'hFFFF_FFFF, "R1 counter reset", a, 32'hFFFF_FFFF);
    rd(4'h4, a); check(a == 32'hFFFF_FFFF, "R1 load reset", a, 32'hFFFF_FFFF);
    rd(4'hC, a); check(a == 0, "R1 ctrl reset", a, 0);
    check(outs() == 0, "R1 outputs low", outs(), 0);

    // R2 restart and unmapped offsets read zero
    rd(4'h8, a); check(a == 0, "R2 restart reads zero", a, 0);
    rd(4'h2, a); check(a == 0, "R2 unmapped reads zero", a, 0);

    // R3 wrong key ignored, right key reloads
    wr(4'h4, 32'd20);
    rd(4'h4, a); check(a == 20, "R2 load readback", a, 20);
    wr(4'h8, 32'h0000_1234);
    rd(4'h0, a); check(a == 32'hFFFF_FFFF, "R3 wrong key ignored", a, 32'hFFFF_FFFF);
    wr(4'h8, 32'h0001_5AB9);
    rd(4'h0, a); check(a == 32'hFFFF_FFFF, "R3 upper bits must be zero", a, 32'hFFFF_FFFF);
    wr(4'h8, KEY);
    rd(4'h0, a); check(a == 20, "R3 key reload", a, 20);

    // R9 gates set but not enabled: no counting
    wr(4'hC, 32'h02);
    rd(4'h0, a); repeat (4) @(negedge clk);
    check(regRdata == a, "R9 disabled holds", regRdata, a);

    // R4 decrement per clock
    wr(4'hC, 32'h03);
    rd(4'h0, a); repeat (5) @(negedge clk); b = regRdata;
    check(a - b == 5, "R4 one per clock", a - b, 5);

    // R6/R7 expiry with reset gate only
    repeat (30) @(negedge clk);
    check(regRdata == 0, "R6 counter at zero", regRdata, 0);
    check(outs() == 32'h1, "R7 reset request only", outs(), 32'h1);
    repeat (10) @(negedge clk);
    check(regRdata == 0, "R6 no wrap", regRdata, 0);
    check(outs() == 32'h1, "R8 sticky", outs(), 32'h1);

    // R7 all gates
    wr(4'hC, 32'h0F);
    @(negedge clk);
    check(outs() == 32'h7, "R7 all outputs", outs(), 32'h7);

    // R8 key restart clears expiry
    wr(4'h8, KEY);
    @(negedge clk);
    check(outs() == 0, "R8 restart clears", outs(), 0);

    // R9 freeze when enable cleared
    wr(4'hC, 32'h0E);
    rd(4'h0, a); repeat (5) @(negedge clk);
    check(regRdata == a && a != 0, "R9 frozen", regRdata, a);

    // Expire again, then control zero
    wr(4'hC, 32'h0F);
    repeat (40) @(negedge clk);
    check(outs() == 32'h7, "R7 expired again", outs(), 32'h7);
    wr(4'hC, 32'h00);
    @(negedge clk);
    check(outs() == 0, "R8 control zero silences", outs(), 0);
    rd(4'hC, a); check(a == 0, "R8 control reads zero", a, 0);

    // R5 external tick: no edges, no movement
    wr(4'h4, 32'd10);
    wr(4'h8, KEY);
    wr(4'hC, 32'h14);
    wr(4'hC, 32'h15);
    rd(4'h0, a); repeat (5) @(negedge clk);
    check(regRdata == 10, "R5 no edge no tick", regRdata, 10);

    // R5 latency of a single edge
    @(posedge clk); #2 extLevel = 1'b1;
    repeat (4) @(negedge clk);
    check(regRdata == 10, "R5 before third edge", regRdata, 10);
    @(negedge clk);
    check(regRdata == 9, "R5 at third edge", regRdata, 9);
    repeat (6) @(negedge clk);
    check(regRdata == 9, "R5 one drop per edge", regRdata, 9);
    @(posedge clk); #2 extLevel = 1'b0;
    repeat (4) @(negedge clk);

    // R5 rate with a free-running external clock
    extDiv = 0; extRun = 1;
    repeat (8) @(negedge clk);
    a = regRdata; repeat (32) @(negedge clk); b = regRdata;
    check(a - b == 4, "R5 one per external period", a - b, 4);
    repeat (60) @(negedge clk);
    check(regRdata == 0, "R6 external mode at zero", regRdata, 0);
    check(outs() == 32'h2, "R7 interrupt only", outs(), 32'h2);
    extRun = 0;

    wr(4'hC, 32'h00);
    @(negedge clk);
    check(outs() == 0, "R8 final stop", outs(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule